// File: doc/BRIEF.md
# Two-Channel Phase Clock Generator

This block produces the switching clocks for two synchronous buck PWM channels from a single fast system clock. Each channel gets a one-cycle start pulse that opens its switching period, and a sawtooth ramp counter that climbs from zero through the period. The period is a parameter counted in system-clock cycles. The default of 832 cycles gives about 300 kHz per channel from a 250 MHz system clock.

Channel 2 runs at a phase lag behind channel 1, and two mode inputs choose that lag. The aim is to keep the switching edges of one channel away from the PWM decision point of the other. With memory mode off, the two channels are half a period apart. With memory mode on and a battery supply, they run in phase. With memory mode on and a regulated 5 V supply, channel 2 lags by a quarter period.

A mode change is latched only at a channel-1 period boundary. When the lag changes, channel 2 stretches one of its cycles to reach the new phase, so neither channel ever produces a short cycle.

Top module: `phase_clk2`

## Requirements
- R1: While `rst_i` is high, both start outputs are low and both ramp outputs are zero.
- R2: `ch1_ramp_o` counts 0, 1, …, PERIOD-1 and then wraps to 0. `ch1_start_o` is high exactly in the cycles where `ch1_ramp_o` is 0, which includes the first cycle after reset is released.
- R3: With `mem_mode_i` = 0, `ch2_start_o` is high exactly when `ch1_ramp_o` equals PERIOD/2 (180 degrees).
- R4: With `mem_mode_i` = 1 and `src_5v_i` = 0 (battery supply), `ch2_start_o` coincides with `ch1_start_o` (0 degrees).
- R5: With `mem_mode_i` = 1 and `src_5v_i` = 1 (regulated 5 V supply), `ch2_start_o` is high exactly when `ch1_ramp_o` equals PERIOD/4 (90 degrees).
- R6: In steady state, `ch2_ramp_o` equals (`ch1_ramp_o` − lag) mod PERIOD, and restarts at 0 on its own start pulse.
- R7: The mode inputs are sampled only in the last cycle of a channel-1 period, when `ch1_ramp_o` = PERIOD-1. The new lag applies from the next channel-1 start. A mode value that is present earlier and removed before that cycle has no effect.
- R8: `ch2_ramp_o` never exceeds PERIOD-1. It holds at PERIOD-1 while waiting for its next start. Successive `ch2_start_o` pulses are never closer than PERIOD cycles. After a lag change from a to b, the gap is PERIOD + (b − a) if b > a, and 2·PERIOD − (a − b) if b < a.
- R9: After reset, `ch2_ramp_o` sits at PERIOD-1 until the first cycle in which `ch1_ramp_o` equals the lag. In that cycle channel 2 starts. For a zero lag, this is the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mem_mode_i | input | 1 | Memory-supply mode select (1 = tracking mode) |
| src_5v_i | input | 1 | Supply source select (1 = regulated 5 V, 0 = battery) |
| ch1_start_o | output | 1 | Channel 1 period-start pulse |
| ch2_start_o | output | 1 | Channel 2 period-start pulse |
| ch1_ramp_o | output | $clog2(PERIOD) | Channel 1 ramp counter |
| ch2_ramp_o | output | $clog2(PERIOD) | Channel 2 ramp counter |

## Verification
Two things can happen in the same cycle: the mode inputs are latched at the last count of channel 1, and channel 2 decides whether to restart. For a zero lag, that restart decision falls on that very cycle. The bench changes the mode exactly in that latch cycle, and also one period earlier in the middle of a cycle. It also applies a short mode change that is withdrawn one cycle before the latch point. Each case is judged by the channel-1 ramp value at which the next channel-2 start appears, and by the gap to the previous start, which is computed from the old and new lag.

// File: rtl/phase_clk2.sv
module phase_clk2 #(
  parameter int PERIOD = 832
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      mem_mode_i,
  input  logic                      src_5v_i,
  output logic                      ch1_start_o,
  output logic                      ch2_start_o,
  output logic [$clog2(PERIOD)-1:0] ch1_ramp_o,
  output logic [$clog2(PERIOD)-1:0] ch2_ramp_o
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] TOP  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] QTR  = CW'(PERIOD / 4);
  localparam logic [CW-1:0] HALF = CW'(PERIOD / 2);

  logic [CW-1:0] c1, c2, lag;
  logic [CW-1:0] lag_sel, c1_nx, lag_nx;
  logic          wrap1, hit2;

  assign lag_sel = !mem_mode_i ? HALF : (src_5v_i ? QTR : '0);
  assign wrap1   = (c1 == TOP);
  assign c1_nx   = wrap1 ? '0 : c1 + 1'b1;
  assign lag_nx  = wrap1 ? lag_sel : lag;
  assign hit2    = (c2 == TOP) && (c1_nx == lag_nx);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      c1  <= '0;
      lag <= lag_sel;
      c2  <= (lag_sel == '0) ? '0 : TOP;
    end else begin
      c1  <= c1_nx;
      lag <= lag_nx;
      if (hit2)
        c2 <= '0;
      else if (c2 != TOP)
        c2 <= c2 + 1'b1;
    end
  end

  assign ch1_ramp_o  = rst_i ? '0 : c1;
  assign ch2_ramp_o  = rst_i ? '0 : c2;
  assign ch1_start_o = !rst_i && (c1 == '0);
  assign ch2_start_o = !rst_i && (c2 == '0);
endmodule

// File: rtl/phase_clk2_chk.sv
module phase_clk2_chk #(
  parameter int PERIOD = 832
) (
  input logic                      clk_i,
  input logic                      rst_i,
  input logic                      mem_mode_i,
  input logic                      src_5v_i,
  input logic                      ch1_start_o,
  input logic                      ch2_start_o,
  input logic [$clog2(PERIOD)-1:0] ch1_ramp_o,
  input logic [$clog2(PERIOD)-1:0] ch2_ramp_o
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] TOP  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] QTR  = CW'(PERIOD / 4);
  localparam logic [CW-1:0] HALF = CW'(PERIOD / 2);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |-> (!ch1_start_o && !ch2_start_o && ch1_ramp_o == '0 && ch2_ramp_o == '0)); // R1
  AST_RAMP1_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !ch1_start_o |-> ch1_ramp_o == $past(ch1_ramp_o) + 1'b1); // R2
  AST_RAMP1_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (ch1_start_o && !$past(rst_i)) |-> $past(ch1_ramp_o) == TOP); // R2
  AST_CH2_LAG_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    ch2_start_o |-> (ch1_ramp_o == '0 || ch1_ramp_o == QTR || ch1_ramp_o == HALF)); // R3
  AST_CH2_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    ch2_ramp_o <= TOP); // R8
  AST_CH2_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
    (ch2_start_o && !$past(rst_i)) |-> $past(ch2_ramp_o) == TOP); // R8
  AST_CH2_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(ch2_ramp_o) == TOP && !ch2_start_o) |-> ch2_ramp_o == TOP); // R8
endmodule

bind phase_clk2 phase_clk2_chk #(.PERIOD(PERIOD)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .mem_mode_i(mem_mode_i), .src_5v_i(src_5v_i),
  .ch1_start_o(ch1_start_o), .ch2_start_o(ch2_start_o),
  .ch1_ramp_o(ch1_ramp_o), .ch2_ramp_o(ch2_ramp_o)
);

// File: tb/phase_clk2_test.sv
module phase_clk2_test;
  localparam int P  = 832;
  localparam int CW = $clog2(P);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem = 1'b0;
  logic src = 1'b0;
  logic s1, s2;
  logic [CW-1:0] r1, r2;

  int n_tests = 0, n_fail = 0;
  int ph = 0, cyc = 0, last_s2 = -100000, last_gap = 0, bad_r2 = 0;

  always #2 clk = ~clk;

  phase_clk2 #(.PERIOD(P)) uut (
    .clk_i(clk), .rst_i(rst), .mem_mode_i(mem), .src_5v_i(src),
    .ch1_start_o(s1), .ch2_start_o(s2), .ch1_ramp_o(r1), .ch2_ramp_o(r2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic obs();
    if (s2) begin
      last_gap = cyc - last_s2;
      last_s2  = cyc;
    end
    if (int'(r2) > P - 1) bad_r2++;
  endtask

  task automatic step();
    @(negedge clk); #1;
    ph = (ph + 1) % P;
    cyc++;
    obs();
  endtask

  task automatic run_to(input int target);
    while (ph != target) step();
  endtask

  task automatic wait_s2();
    int k = 0;
    do begin step(); k++; end while (!s2 && k < 3 * P);
  endtask

  task automatic do_reset(input bit m, input bit s);
    int bad = 0;
    rst = 1'b1; mem = m; src = s;
    repeat (4) begin
      @(negedge clk); #1;
      if (s1 || s2 || r1 != 0 || r2 != 0) bad++;
    end
    chk(bad == 0, "R1", bad, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    ph = 0; cyc = 0; last_s2 = -100000;
    obs();
    chk(s1 && r1 == 0, "R2", int'(r1), 0);
  endtask

  task automatic sync(input int off, input string req);
    int bad = 0, k = 0;
    while (!s2 && k < 2 * P) begin
      if (int'(r2) != P - 1) bad++;
      step(); k++;
    end
    chk(bad == 0, "R9", bad, 0);
    chk(s2 && ph == off, req, ph, off);
  endtask

  task automatic window(input int nper, input int off, input string req);
    int e1 = 0, e2 = 0, e3 = 0;
    repeat (nper * P) begin
      step();
      if (int'(r1) != ph || s1 != (ph == 0)) e1++;
      if (s2 != (ph == off)) e2++;
      if (int'(r2) != (ph - off + P) % P) e3++;
    end
    chk(e1 == 0, "R2", e1, 0);
    chk(e2 == 0, req, e2, 0);
    chk(e3 == 0, "R6", e3, 0);
  endtask

  task automatic t_switch(input bit m, input bit s, input int old_off, input int new_off,
                          input int at_ph, input int exp_gap, input string req);
    run_to(at_ph);
    mem = m; src = s;
    if (at_ph < old_off) begin
      wait_s2();
      chk(ph == old_off, "R7", ph, old_off);
      chk(last_gap == P, "R8", last_gap, P);
    end
    wait_s2();
    chk(ph == new_off, req, ph, new_off);
    chk(last_gap == exp_gap, "R8", last_gap, exp_gap);
    wait_s2();
    chk(last_gap == P, "R8", last_gap, P);
    window(1, new_off, req);
  endtask

  task automatic t_glitch();
    run_to(P - 3);
    src = 1'b1;
    step();
    src = 1'b0;
    wait_s2();
    chk(ph == 0, "R7", ph, 0);
    chk(last_gap == P, "R7", last_gap, P);
  endtask

  initial begin
    do_reset(1'b0, 1'b0);
    sync(P / 2, "R3");
    window(2, P / 2, "R3");
    t_switch(1'b1, 1'b0, P / 2, 0, 10, P + P / 2, "R4");
    t_glitch();
    t_switch(1'b1, 1'b1, 0, P / 4, P - 1, P + P / 4, "R5");
    t_switch(1'b0, 1'b0, P / 4, P / 2, 5, P + P / 4, "R3");
    do_reset(1'b1, 1'b1);
    sync(P / 4, "R5");
    window(2, P / 4, "R5");
    t_switch(1'b1, 1'b0, P / 4, 0, P / 2, 2 * P - P / 4, "R4");
    do_reset(1'b1, 1'b0);
    sync(0, "R9");
    window(1, 0, "R4");
    chk(bad_r2 == 0, "R8", bad_r2, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule